// File: doc/BRIEF.md
# Start/Stop Character Serializer

This block sends one character at a time over a single serial line using start/stop framing. A producer offers a parallel character with a valid/ready handshake, together with the character length, parity choice and stop length to use. Once accepted, the character goes out as a frame: a low start element, the data bits with the least significant first, an optional parity bit, and a high stop element.

Timing comes from a single-cycle enable, `half_tick_i`, that pulses twice per bit-time. Ordinary elements last two pulses. The stop element lasts two, three or four pulses, which gives one, one-and-a-half or two bit-times. The configuration is taken in together with the character, so every frame can use a different format. When no new character is offered, the line simply stays high, and a character held ready at the end of a frame starts exactly when the minimum stop length has run out.

Top module: `async_char_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_o` is 1, `char_ready_o` is 1 and `busy_o` is 0.
- R2: A character is accepted on a clock edge where `char_valid_i` and `char_ready_o` are both 1. The next element on `line_o` is a start element at 0 that lasts exactly 2 half-ticks.
- R3: After the start element the data bits follow, least significant bit first, each lasting 2 half-ticks. There are 5 + `len_sel_i` of them, so code 0 gives 5 bits and code 3 gives 8 bits.
- R4: When `par_sel_i` is 1 (even) or 2 (odd), one parity bit lasting 2 half-ticks follows the last data bit. The parity bit makes the number of ones across the data bits and the parity bit even for code 1 and odd for code 2.
- R5: When `par_sel_i` is 0 or 3, there is no parity slot, and the stop element begins right after the last data bit.
- R6: The stop element is 1 and lasts at least 2, 3 or 4 half-ticks for `stop_sel_i` codes 0, 1 and 2. Code 3 behaves like code 2.
- R7: After the minimum stop length the line stays at 1 until the next acceptance. A character that is already valid is accepted without adding any half-tick to the gap, so back-to-back frames are separated by exactly the minimum stop length.
- R8: `char_ready_o` is 1 only when no frame is in progress, and `busy_o` is its complement. It goes to 0 from the cycle after an acceptance until the minimum stop length has elapsed.
- R9: The character and all three configuration inputs are captured at acceptance. Changing them during a frame has no effect on that frame's bits or durations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_tick_i | input | 1 | Enable pulse, two per bit-time |
| char_i | input | DATA_W | Character to send, bit 0 sent first |
| char_valid_i | input | 1 | Character offered |
| char_ready_o | output | 1 | Serializer can accept a character |
| len_sel_i | input | LEN_W | Data bit count minus MIN_BITS |
| par_sel_i | input | 2 | 0/3 none, 1 even, 2 odd |
| stop_sel_i | input | 2 | 0: 1 bit, 1: 1.5 bits, 2/3: 2 bits |
| line_o | output | 1 | Serial line, 1 is idle/stop level |
| busy_o | output | 1 | Frame in progress |

## Verification
The assertions and the tick-based checks assume that `half_tick_i` is a single-cycle pulse and that consecutive pulses are at least three clocks apart, so that an acceptance always fits between the last stop pulse and the next pulse. The bench generates the pulse every fourth clock. The bench also drives `char_i` and the configuration only on falling edges, and it holds them stable from the moment it raises `char_valid_i` until the acceptance edge. Inputs are changed during a frame only in the directed test that checks they are ignored.

// File: rtl/actx_pkg.sv
package actx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  // stop length in half-ticks minus one: 1, 1.5, 2, 2 bit-times
  function automatic logic [1:0] stop_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/actx_frame_pack.sv
module actx_frame_pack #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  parameter int IDX_W    = 3
) (
  input  logic [DATA_W-1:0] char_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic [1:0]        stop_sel_i,
  output logic [IDX_W-1:0]  nlast_o,
  output logic              par_en_o,
  output logic              par_bit_o,
  output logic [1:0]        stop_last_o
);
  logic [DATA_W-1:0] used;
  logic              ones_odd;

  assign nlast_o = IDX_W'(MIN_BITS - 1) + IDX_W'(len_sel_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign used[i] = char_i[i] & (IDX_W'(i) <= nlast_o);
  end

  assign ones_odd    = ^used;
  assign par_en_o    = (par_sel_i == 2'd1) || (par_sel_i == 2'd2);
  assign par_bit_o   = ones_odd ^ (par_sel_i == 2'd2);
  assign stop_last_o = actx_pkg::stop_last(stop_sel_i);
endmodule

// File: rtl/actx_seq.sv
module actx_seq
  import actx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_tick_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic [IDX_W-1:0]  nlast_i,
  input  logic              par_en_i,
  input  logic              par_bit_i,
  input  logic [1:0]        stop_last_i,
  output logic              ready_o,
  output logic              line_o
);
  tx_state_e         state_q;
  logic [1:0]        tcnt_q, stop_last_q, el_last;
  logic [IDX_W-1:0]  bidx_q, nlast_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_en_q, par_bit_q, line_q;
  logic              accept, el_done;

  assign ready_o = (state_q == ST_IDLE);
  assign line_o  = line_q;
  assign accept  = valid_i && ready_o;
  assign el_last = (state_q == ST_STOP) ? stop_last_q : 2'd1;
  assign el_done = half_tick_i && (tcnt_q == el_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tcnt_q      <= '0;
      bidx_q      <= '0;
      nlast_q     <= '0;
      sh_q        <= '0;
      par_en_q    <= 1'b0;
      par_bit_q   <= 1'b0;
      stop_last_q <= 2'd1;
      line_q      <= 1'b1;
    end else if (accept) begin
      state_q     <= ST_START;
      tcnt_q      <= '0;
      bidx_q      <= '0;
      nlast_q     <= nlast_i;
      sh_q        <= char_i;
      par_en_q    <= par_en_i;
      par_bit_q   <= par_bit_i;
      stop_last_q <= stop_last_i;
      line_q      <= 1'b0;
    end else if (state_q != ST_IDLE && half_tick_i) begin
      if (!el_done) begin
        tcnt_q <= tcnt_q + 2'd1;
      end else begin
        tcnt_q <= '0;
        case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            line_q  <= sh_q[0];
          end
          ST_DATA: begin
            if (bidx_q == nlast_q) begin
              state_q <= par_en_q ? ST_PARITY : ST_STOP;
              line_q  <= par_en_q ? par_bit_q : 1'b1;
            end else begin
              bidx_q <= bidx_q + 1'b1;
              sh_q   <= sh_q >> 1;
              line_q <= sh_q[1];
            end
          end
          ST_PARITY: begin
            state_q <= ST_STOP;
            line_q  <= 1'b1;
          end
          default: begin
            state_q <= ST_IDLE;
            line_q  <= 1'b1;
          end
        endcase
      end
    end
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> line_o);
  // R2
  start_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!line_o && !ready_o));
  // R3
  bit_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (bidx_q <= nlast_q));
  // R6
  stop_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> line_o);
  // R6
  tick_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_STOP) |-> (tcnt_q <= 2'd1));
  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !accept) |=> ($stable(nlast_q) && $stable(stop_last_q)
                               && $stable(par_en_q) && $stable(par_bit_q)));
endmodule

// File: rtl/async_char_tx.sv
module async_char_tx #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  localparam int LEN_W   = $clog2(DATA_W - MIN_BITS + 1),
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_tick_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              char_valid_i,
  output logic              char_ready_o,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic [1:0]        stop_sel_i,
  output logic              line_o,
  output logic              busy_o
);
  logic [IDX_W-1:0] nlast;
  logic             par_en, par_bit;
  logic [1:0]       stop_last;

  actx_frame_pack #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_pack (
    .char_i     (char_i),
    .len_sel_i  (len_sel_i),
    .par_sel_i  (par_sel_i),
    .stop_sel_i (stop_sel_i),
    .nlast_o    (nlast),
    .par_en_o   (par_en),
    .par_bit_o  (par_bit),
    .stop_last_o(stop_last)
  );

  actx_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_tick_i(half_tick_i),
    .valid_i    (char_valid_i),
    .char_i     (char_i),
    .nlast_i    (nlast),
    .par_en_i   (par_en),
    .par_bit_i  (par_bit),
    .stop_last_i(stop_last),
    .ready_o    (char_ready_o),
    .line_o     (line_o)
  );

  assign busy_o = !char_ready_o;

  // R8
  busy_ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && char_ready_o) |=> busy_o);
endmodule

// File: tb/async_char_tx_test.sv
module async_char_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       half_tick_i = 1'b0;
  logic [7:0] char_i = '0;
  logic       char_valid_i = 1'b0;
  logic       char_ready_o;
  logic [1:0] len_sel_i = '0;
  logic [1:0] par_sel_i = '0;
  logic [1:0] stop_sel_i = '0;
  logic       line_o;
  logic       busy_o;

  typedef struct {
    logic  v;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;
  int   tdiv = 0;

  async_char_tx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_tick_i(half_tick_i),
    .char_i(char_i), .char_valid_i(char_valid_i), .char_ready_o(char_ready_o),
    .len_sel_i(len_sel_i), .par_sel_i(par_sel_i), .stop_sel_i(stop_sel_i),
    .line_o(line_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    #1;
    tdiv = (tdiv + 1) % TICK_DIV;
    half_tick_i = (tdiv == 0);
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s = %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle monitor: ready/busy follow frame occupancy, line checked at each half-tick
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R8", "char_ready_o", char_ready_o, exp_q.size() == 0);
      check("R8", "busy_o", busy_o, exp_q.size() != 0);
      if (half_tick_i) begin
        if (exp_q.size() != 0) begin
          check(exp_q[0].tag, "line_o", line_o, exp_q[0].v);
          void'(exp_q.pop_front());
        end else begin
          check("R7", "line_o idle", line_o, 1'b1);
        end
      end
    end
  end

  task automatic push(input logic v, input string tag, input string ovr);
    exp_t e;
    e.v = v;
    e.tag = (ovr != "") ? ovr : tag;
    exp_q.push_back(e);
  endtask

  task automatic push_frame(input logic [7:0] ch, input int ls, input int ps,
                            input int ss, input string ovr);
    int   n  = 5 + ls;
    bit   pe = (ps == 1) || (ps == 2);
    logic pb = (ps == 2);
    int   st = (ss == 0) ? 2 : (ss == 1) ? 3 : 4;
    for (int i = 0; i < n; i++) pb ^= ch[i];
    push(1'b0, "R2", ovr); push(1'b0, "R2", ovr);
    for (int i = 0; i < n; i++) begin
      push(ch[i], "R3", ovr); push(ch[i], "R3", ovr);
    end
    if (pe) begin
      push(pb, "R4", ovr); push(pb, "R4", ovr);
    end
    for (int i = 0; i < st; i++) push(1'b1, (!pe && i == 0) ? "R5" : "R6", ovr);
  endtask

  task automatic send(input logic [7:0] ch, input int ls, input int ps,
                      input int ss, input string ovr);
    @(negedge clk_i);
    char_i = ch; len_sel_i = ls[1:0]; par_sel_i = ps[1:0]; stop_sel_i = ss[1:0];
    char_valid_i = 1'b1;
    while (!char_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1;
    push_frame(ch, ls, ps, ss, ovr);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk_i);
    char_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drain();
    @(negedge clk_i);
    char_valid_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: frames outstanding = %0d expected 0", exp_q.size());
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", "line_o", line_o, 1'b1);
    check("R1", "char_ready_o", char_ready_o, 1'b1);
    check("R1", "busy_o", busy_o, 1'b0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    check("R1", "line_o after reset", line_o, 1'b1);

    // full sweep of formats, back-to-back runs with occasional idle gaps
    for (int ls = 0; ls < 4; ls++)
      for (int ps = 0; ps < 4; ps++)
        for (int ss = 0; ss < 4; ss++) begin
          for (int k = 0; k < 3; k++)
            send(8'((ls * 37 + ps * 11 + ss * 5 + k * 91 + 3) ^ (k * 8'h6c)), ls, ps, ss, "");
          if (((ls + ss + ps) % 2) == 1) go_idle(9 + 3 * ss);
        end
    drain();

    // R9: inputs changed right after acceptance must not alter the frame
    send(8'h5a, 3, 1, 2, "R9");
    @(negedge clk_i);
    char_valid_i = 1'b0;
    char_i = 8'hff; len_sel_i = 2'd0; par_sel_i = 2'd2; stop_sel_i = 2'd0;
    while (exp_q.size() != 0) @(negedge clk_i);

    // R7: long idle after stop keeps line high
    repeat (40) @(negedge clk_i);
    send(8'h01, 0, 2, 1, "");
    drain();
    repeat (8) @(negedge clk_i);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule